// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Occupancy Flags

This block is a single-clock first-in first-out buffer for 18-bit words with a parameterised depth. One port side accepts words under a write strobe, the other releases them under a read strobe. Read data is registered, so a word appears on the output port one clock after its read is accepted. Five status outputs report how full the buffer is: empty, almost-empty, half-full, almost-full and full.

The almost-empty and almost-full thresholds come from two offset registers. Both reset to 127. Either one can be reloaded through a small configuration port, but only in a cycle with no traffic. A rewind input sends the read side back to storage location zero, so data already read can be replayed.

A three-state occupancy machine drives the empty and full outputs. Its states are `ST_EMPTY` (no words held), `ST_FILL` (between one and DEPTH-1 words) and `ST_FULL` (DEPTH words). Its transitions are:
- fill: `ST_EMPTY`→`ST_FILL` on an accepted write, or on a rewind while the write pointer is not zero.
- top-off: `ST_FILL`→`ST_FULL` on a lone write at DEPTH-1 words.
- drain: `ST_FILL`→`ST_EMPTY` on a lone read at one word, or on a rewind while the write pointer is zero.
- release: `ST_FULL`→`ST_FILL` on an accepted read, or on a rewind while the write pointer is not zero.
- flush: `ST_FULL`→`ST_EMPTY` on a rewind while the write pointer is zero.

Top module: `occ_fifo`

## Requirements
- R1: An active-low asynchronous reset clears both pointers and the word count and drives rd_data to 0. After reset, empty and almost_empty read 1 and half_full, almost_full and full read 0.
- R2: While full is 1, a write strobe is ignored. The stored contents and the word count do not change.
- R3: While empty is 1, a read strobe is ignored. rd_data holds its value and the read pointer does not advance.
- R4: After reset, both the almost-empty offset and the almost-full offset hold 127.
- R5: almost_empty is 1 exactly when the word count is less than or equal to the almost-empty offset.
- R6: almost_full is 1 exactly when the word count is greater than or equal to DEPTH minus the almost-full offset.
- R7: half_full is 1 exactly when the word count is greater than DEPTH/2.
- R8: A read accepted at a clock edge puts the addressed word on rd_data after that edge. The first word written into an empty FIFO can therefore be read in the cycle after empty falls.
- R9: A rewind pulse (rexmit=1) sets the read pointer to location 0 and sets the word count to the write pointer value. The read and write strobes are ignored in that cycle. Later reads return the earlier data in the order it was written.
- R10: A read and a write accepted in the same cycle leave the word count unchanged.
- R11: cfg_load=1 writes cfg_value into the almost-empty offset when cfg_sel=0 and into the almost-full offset when cfg_sel=1. The load takes effect only in a cycle where wr_en, rd_en and rexmit are all 0; otherwise it is ignored.
- R12: empty is 1 exactly when the word count is 0, and full is 1 exactly when the word count equals DEPTH. All flags change on the same clock edge as the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 18 | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 18 | Registered read word |
| rexmit | input | 1 | Rewind the read side to location 0 |
| cfg_load | input | 1 | Offset load strobe |
| cfg_sel | input | 1 | 0 selects the almost-empty offset, 1 the almost-full offset |
| cfg_value | input | 8 | Offset value to load (log2 DEPTH bits) |
| empty | output | 1 | No words held |
| almost_empty | output | 1 | Count at or below the almost-empty offset |
| half_full | output | 1 | Count above DEPTH/2 |
| almost_full | output | 1 | Count at or above DEPTH minus the almost-full offset |
| full | output | 1 | DEPTH words held |

## Verification
Some properties are checked by assertions on every cycle:
- empty and full agree with the counter.
- Strobes at the full and empty boundaries change nothing.
- A paired read and write keeps the count steady.
- The read pointer moves only on a read or a rewind.
- A rewind lands the read pointer on location zero with the count taken from the write pointer.
- A load during traffic leaves both offsets as they were.

Other behaviour only the bench scenarios can show, through the data that comes out:
- the order and values of replayed words;
- the exact thresholds at which each occupancy flag switches with default and reloaded offsets;
- the one-cycle latency of the first word after empty falls.

// File: rtl/occ_fifo_pkg.sv
package occ_fifo_pkg;

    // Occupancy state of the buffer
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_FULL  = 2'd2
    } fill_state_t;

    // Selector values on the configuration port (R11)
    localparam logic SEL_EMPTY_OFS = 1'b0;
    localparam logic SEL_FULL_OFS  = 1'b1;

    // Number of offset registers
    localparam int NUM_OFS = 2;

endpackage

// File: rtl/occ_fifo_mem.sv
module occ_fifo_mem #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_ok,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] store [DEPTH];

    // Storage array: written only on accepted writes, never reset
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Registered read port: updates only on accepted reads (R8, R3)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_ok) begin
            rd_data <= store[rd_addr];
        end
    end

endmodule

// File: rtl/occ_fifo_ptrs.sv
module occ_fifo_ptrs #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ok,
    input  logic          rd_ok,
    input  logic          rexmit,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_ADDR) ? '0 : p + AW'(1);
    endfunction

    // Write pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (wr_ok) begin
            wr_ptr <= bump(wr_ptr);
        end
    end

    // Read pointer, with rewind to location zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (rexmit) begin
            rd_ptr <= '0;
        end else if (rd_ok) begin
            rd_ptr <= bump(rd_ptr);
        end
    end

    // Occupancy counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (rexmit) begin
            count <= {1'b0, wr_ptr};
        end else begin
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assert_rdptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ok && !rexmit) |=> $stable(rd_ptr));

    assert_balanced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && wr_ok && !rexmit) |=> $stable(count));

    assert_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rexmit |=> (rd_ptr == '0) && (count == {1'b0, $past(wr_ptr)}));

endmodule

// File: rtl/occ_fifo_flags.sv
module occ_fifo_flags
    import occ_fifo_pkg::*;
#(
    parameter int DEPTH      = 256,
    parameter int DEF_OFFSET = 127,
    localparam int AW        = $clog2(DEPTH),
    localparam int CW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          busy,
    input  logic          cfg_load,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_value,
    output logic          almost_empty,
    output logic          half_full,
    output logic          almost_full
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

    logic [AW-1:0] ofs [NUM_OFS];

    // One offset register per selector value (R4, R11)
    for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ofs[g] <= AW'(DEF_OFFSET);
            end else if (cfg_load && !busy && (cfg_sel == 1'(g))) begin
                ofs[g] <= cfg_value;
            end
        end
    end

    logic [CW-1:0] af_threshold;

    always_comb begin
        af_threshold = DEPTH_C - {1'b0, ofs[SEL_FULL_OFS]};
        almost_empty = (count <= {1'b0, ofs[SEL_EMPTY_OFS]});
        almost_full  = (count >= af_threshold);
        half_full    = (count > HALF_C);
    end

    assert_cfg_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ofs[0]) && $stable(ofs[1])));

endmodule

// File: rtl/occ_fifo.sv
module occ_fifo
    import occ_fifo_pkg::*;
#(
    parameter int WIDTH      = 18,
    parameter int DEPTH      = 256,
    parameter int DEF_OFFSET = 127,
    localparam int AW        = $clog2(DEPTH),
    localparam int CW        = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rexmit,
    input  logic             cfg_load,
    input  logic             cfg_sel,
    input  logic [AW-1:0]    cfg_value,
    output logic             empty,
    output logic             almost_empty,
    output logic             half_full,
    output logic             almost_full,
    output logic             full
);

    localparam logic [CW-1:0] DEPTH_C   = CW'(DEPTH);
    localparam logic [CW-1:0] NEAR_FULL = CW'(DEPTH - 1);

    fill_state_t   state, state_nx;
    logic          wr_ok, rd_ok, busy;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    // Acceptance: the full and empty states gate the strobes; a rewind gates both
    always_comb begin
        wr_ok = wr_en && (state != ST_FULL)  && !rexmit;
        rd_ok = rd_en && (state != ST_EMPTY) && !rexmit;
        busy  = wr_en || rd_en || rexmit;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: begin
                if (rexmit) begin
                    state_nx = (wr_ptr != '0) ? ST_FILL : ST_EMPTY;
                end else if (wr_ok) begin
                    state_nx = ST_FILL;
                end
            end
            ST_FILL: begin
                if (rexmit) begin
                    state_nx = (wr_ptr != '0) ? ST_FILL : ST_EMPTY;
                end else if (wr_ok && !rd_ok && (count == NEAR_FULL)) begin
                    state_nx = ST_FULL;
                end else if (rd_ok && !wr_ok && (count == CW'(1))) begin
                    state_nx = ST_EMPTY;
                end
            end
            ST_FULL: begin
                if (rexmit) begin
                    state_nx = (wr_ptr != '0) ? ST_FILL : ST_EMPTY;
                end else if (rd_ok) begin
                    state_nx = ST_FILL;
                end
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    // Outputs from state
    always_comb begin
        empty = (state == ST_EMPTY);
        full  = (state == ST_FULL);
    end

    occ_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok),
        .rexmit (rexmit),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (count)
    );

    occ_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (wr_ok),
        .wr_addr (wr_ptr),
        .wr_data (wr_data),
        .rd_ok   (rd_ok),
        .rd_addr (rd_ptr),
        .rd_data (rd_data)
    );

    occ_fifo_flags #(.DEPTH(DEPTH), .DEF_OFFSET(DEF_OFFSET)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .count        (count),
        .busy         (busy),
        .cfg_load     (cfg_load),
        .cfg_sel      (cfg_sel),
        .cfg_value    (cfg_value),
        .almost_empty (almost_empty),
        .half_full    (half_full),
        .almost_full  (almost_full)
    );

    assert_full_matches_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) == (count == DEPTH_C));

    assert_empty_matches_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) == (count == '0));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !rexmit) |=> (full && $stable(count)));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en && !rexmit) |=> (empty && $stable(rd_data)));

endmodule

// File: tb/occ_fifo_tb.sv
`timescale 1ns/1ps
module occ_fifo_tb;

    localparam int W = 18;
    localparam int D = 256;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, rexmit = 1'b0, cfg_load = 1'b0, cfg_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [AW-1:0] cfg_value = '0;
    logic [W-1:0] rd_data;
    logic empty, almost_empty, half_full, almost_full, full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    occ_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rexmit(rexmit),
        .cfg_load(cfg_load), .cfg_sel(cfg_sel), .cfg_value(cfg_value),
        .empty(empty), .almost_empty(almost_empty), .half_full(half_full),
        .almost_full(almost_full), .full(full)
    );

    // Behavioural reference model
    logic [W-1:0] mdl_mem [D];
    int mdl_wp, mdl_rp, mdl_cnt, mdl_ofs_e, mdl_ofs_f;
    logic [W-1:0] mdl_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            mdl_wp = 0; mdl_rp = 0; mdl_cnt = 0;
            mdl_ofs_e = 127; mdl_ofs_f = 127; mdl_rd = '0;
        end else begin
            bit wok, rok;
            wok = wr_en && (mdl_cnt < D) && !rexmit;
            rok = rd_en && (mdl_cnt > 0) && !rexmit;
            if (cfg_load && !wr_en && !rd_en && !rexmit) begin
                if (cfg_sel) mdl_ofs_f = int'(cfg_value);
                else         mdl_ofs_e = int'(cfg_value);
            end
            if (rexmit) begin
                mdl_rp = 0;
                mdl_cnt = mdl_wp;
            end else begin
                if (rok) begin
                    mdl_rd = mdl_mem[mdl_rp];
                    mdl_rp = (mdl_rp + 1) % D;
                end
                if (wok) begin
                    mdl_mem[mdl_wp] = wr_data;
                    mdl_wp = (mdl_wp + 1) % D;
                end
                mdl_cnt = mdl_cnt + int'(wok) - int'(rok);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always begin
        @(posedge clk);
        #1;
        chk(rd_data == mdl_rd, "R8", "rd_data", int'(rd_data), int'(mdl_rd));
        chk(empty == (mdl_cnt == 0), "R12", "empty", int'(empty), int'(mdl_cnt == 0));
        chk(full == (mdl_cnt == D), "R12", "full", int'(full), int'(mdl_cnt == D));
        chk(almost_empty == (mdl_cnt <= mdl_ofs_e), "R5", "almost_empty",
            int'(almost_empty), int'(mdl_cnt <= mdl_ofs_e));
        chk(almost_full == (mdl_cnt >= D - mdl_ofs_f), "R6", "almost_full",
            int'(almost_full), int'(mdl_cnt >= D - mdl_ofs_f));
        chk(half_full == (mdl_cnt > D / 2), "R7", "half_full",
            int'(half_full), int'(mdl_cnt > D / 2));
    end

    function automatic logic [W-1:0] pat(input int i);
        return W'((i * 37 + 5) & 18'h3FFFF);
    endfunction

    task automatic push(input logic [W-1:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle_load(input logic sel, input logic [AW-1:0] v);
        cfg_load = 1'b1; cfg_sel = sel; cfg_value = v;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        logic [W-1:0] held;
        int n;
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);
        chk(almost_empty == 1'b1, "R1", "almost_empty after reset", int'(almost_empty), 1);
        chk(half_full == 1'b0, "R1", "half_full after reset", int'(half_full), 0);
        chk(almost_full == 1'b0, "R1", "almost_full after reset", int'(almost_full), 0);
        chk(full == 1'b0, "R1", "full after reset", int'(full), 0);
        chk(rd_data == '0, "R1", "rd_data after reset", int'(rd_data), 0);

        // R8: first word latency
        push(18'h01234);
        chk(empty == 1'b0, "R8", "empty falls after write", int'(empty), 0);
        pop();
        chk(rd_data == 18'h01234, "R8", "first word", int'(rd_data), 'h1234);
        chk(empty == 1'b1, "R8", "empty after single read", int'(empty), 1);

        // R4..R7, R12, R2: fill with default offsets
        for (int i = 0; i < 127; i++) push(pat(i));
        chk(almost_empty == 1'b1, "R4", "almost_empty at 127", int'(almost_empty), 1);
        push(pat(127));
        chk(almost_empty == 1'b0, "R4", "almost_empty at 128", int'(almost_empty), 0);
        chk(half_full == 1'b0, "R7", "half_full at 128", int'(half_full), 0);
        chk(almost_full == 1'b0, "R6", "almost_full at 128", int'(almost_full), 0);
        push(pat(128));
        chk(half_full == 1'b1, "R7", "half_full at 129", int'(half_full), 1);
        chk(almost_full == 1'b1, "R4", "almost_full at 129", int'(almost_full), 1);
        for (int i = 129; i < D; i++) push(pat(i));
        chk(full == 1'b1, "R12", "full at DEPTH", int'(full), 1);
        push(18'h3FFFF);
        chk(full == 1'b1, "R2", "full after ignored write", int'(full), 1);
        for (int i = 0; i < D; i++) pop();
        chk(rd_data == pat(D - 1), "R2", "last word not overwritten", int'(rd_data), int'(pat(D - 1)));
        chk(empty == 1'b1, "R12", "empty after drain", int'(empty), 1);

        // R3: reads while empty are ignored
        held = rd_data;
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data == held, "R3", "rd_data held while empty", int'(rd_data), int'(held));
        push(18'h2AAAA);
        pop();
        chk(rd_data == 18'h2AAAA, "R3", "pointer did not move", int'(rd_data), 'h2AAAA);

        // R10: paired read and write keep the count
        for (int i = 0; i < 10; i++) push(pat(300 + i));
        wr_en = 1'b1; rd_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            wr_data = pat(400 + i);
            @(negedge clk);
        end
        wr_en = 1'b0; rd_en = 1'b0;
        n = 0;
        while (!empty && n < D + 2) begin
            pop();
            n++;
        end
        chk(n == 10, "R10", "words left after paired traffic", n, 10);

        // R11: offset loading
        idle_load(1'b0, 8'd3);
        idle_load(1'b1, 8'd2);
        for (int i = 0; i < 3; i++) push(pat(500 + i));
        chk(almost_empty == 1'b1, "R11", "almost_empty at 3 with offset 3", int'(almost_empty), 1);
        cfg_load = 1'b1; cfg_sel = 1'b0; cfg_value = 8'd50;
        push(pat(503));
        cfg_load = 1'b0;
        chk(almost_empty == 1'b0, "R11", "busy load ignored, almost_empty at 4", int'(almost_empty), 0);
        for (int i = 4; i < 253; i++) push(pat(500 + i));
        chk(almost_full == 1'b0, "R11", "almost_full at 253 with offset 2", int'(almost_full), 0);
        push(pat(753));
        chk(almost_full == 1'b1, "R11", "almost_full at 254 with offset 2", int'(almost_full), 1);
        while (!empty) pop();

        // R9: rewind and replay
        do_reset();
        for (int i = 0; i < 6; i++) push(pat(900 + i));
        for (int i = 0; i < 4; i++) pop();
        rexmit = 1'b1; wr_en = 1'b1; wr_data = 18'h15555; rd_en = 1'b1;
        @(negedge clk);
        rexmit = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        chk(empty == 1'b0, "R9", "not empty after rewind", int'(empty), 0);
        for (int i = 0; i < 6; i++) begin
            pop();
            chk(rd_data == pat(900 + i), "R9", "replayed word", int'(rd_data), int'(pat(900 + i)));
        end
        chk(empty == 1'b1, "R9", "empty after replay", int'(empty), 1);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule